// File: doc/BRIEF.md
# Receive Descriptor List Walker

This block keeps the address of the current receive descriptor for one priority queue of a network receiver. Software loads a starting descriptor address while the walker is idle, then starts it with an enable strobe that carries a queue-select vector. The receive engine reports when it has finished with the current descriptor. The walker then reads that descriptor's link word through a simple read request/response port and moves on to the address it finds there.

A link word of zero ends the list. The walker then stays parked on the last descriptor. Each later enable strobe for this queue reads that link word again, so descriptors that software appended in the meantime are picked up without reloading the pointer. Descriptor addresses are 8-byte aligned. A software load whose three low bits are not zero is aligned by clearing those bits, and a sticky flag records that this happened.

Top module: `rx_desc_walker`

## Requirements
- R1: After the asynchronous hard reset, and one cycle after a synchronous soft-reset pulse, the walker is idle. `cur_ptr` is 0 and `end_of_list`, `walker_busy`, `misalign_flag` and `rd_req_valid` are all 0.
- R2: A pointer write is taken only while `walker_busy` is 0, and it takes effect on the next clock. While the walker is busy, a pointer write leaves `cur_ptr` unchanged.
- R3: The three low bits of `cur_ptr` are always 0. A write whose low three bits are nonzero stores the value with those bits cleared and sets `misalign_flag`. The flag stays set until a reset.
- R4: An enable strobe starts an idle walker (`walker_busy` becomes 1 on the next clock) only when bit `QUEUE_ID` (default 3) of `en_qsel` is 1. With that bit 0, the strobe has no effect.
- R5: A consume pulse while the walker is busy and not parked or fetching raises `rd_req_valid` on the next clock, with `rd_req_addr` equal to `cur_ptr` (the link word sits at offset 0). Valid and address are held until `rd_req_ready` is seen.
- R6: After the request is accepted, the first `rd_rsp_valid` whose data is nonzero once the low three bits are cleared loads that aligned value into `cur_ptr` on the next clock. The walker then waits for the next consume.
- R7: A response whose aligned value is zero leaves `cur_ptr` unchanged and sets `end_of_list` on the next clock.
- R8: While parked, an enable strobe with the queue bit set issues a new read of the current descriptor's link word, after which R6 or R7 applies. A strobe while waiting for consume or while fetching has no effect.
- R9: A consume pulse while idle, parked or fetching issues no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| ptr_wr_en | input | 1 | Software pointer write strobe |
| ptr_wr_data | input | ADDR_W | Pointer write value |
| en_strobe | input | 1 | Software enable strobe |
| en_qsel | input | PRI_W | Queue-select vector sampled with the enable strobe |
| consume | input | 1 | Receive engine finished with current descriptor |
| rd_req_valid | output | 1 | Link-word read request |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Address of the link word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | ADDR_W | Link word read from memory |
| cur_ptr | output | ADDR_W | Current descriptor address |
| end_of_list | output | 1 | Parked on a descriptor with a null link |
| walker_busy | output | 1 | Walker is not idle |
| misalign_flag | output | 1 | Sticky: a software load was misaligned |

## Verification
A wrong state register appears at the ports on the clock after the stimulus that exposes it. For example, the walker might park when it should not, or fail to park when it should. Then `end_of_list` or `walker_busy` is wrong at once, and a consume or strobe either raises a read request that should not exist or fails to raise one. A wrong pointer appears both on `cur_ptr` and on `rd_req_addr` of the next fetch. A request-tracking fault appears as a request that drops before `rd_req_ready`, or as a response that updates the pointer while the request is still pending.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_FETCH  = 2'd1,
        WS_ACTIVE = 2'd2,
        WS_PARKED = 2'd3
    } walk_state_e;
endpackage

// File: rtl/rxw_align.sv
// Clears the low alignment bits of an address and reports whether any were set.
module rxw_align #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 3
) (
    input  logic [ADDR_W-1:0] raw_addr,
    output logic [ADDR_W-1:0] aligned_addr,
    output logic              was_misaligned
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1);

    always_comb begin
        aligned_addr   = raw_addr & ~LOW_MASK;
        was_misaligned = |(raw_addr & LOW_MASK);
    end
endmodule

// File: rtl/rxw_fetch_port.sv
// Tracks one outstanding link-word read: request held until accepted, then waits for data.
module rxw_fetch_port (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic start,
    input  logic rd_req_ready,
    input  logic rd_rsp_valid,
    output logic rd_req_valid,
    output logic rsp_take
);
    typedef struct packed {
        logic pend;
        logic wait_rsp;
    } fp_regs_t;

    fp_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        rsp_take = r_q.wait_rsp & rd_rsp_valid;
        if (r_q.pend && rd_req_ready) begin
            r_d.pend     = 1'b0;
            r_d.wait_rsp = 1'b1;
        end
        if (rsp_take) begin
            r_d.wait_rsp = 1'b0;
        end
        if (start) begin
            r_d.pend = 1'b1;
        end
        if (soft_rst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_req_valid = r_q.pend;
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 3,
    parameter int PRI_W      = 4,
    parameter int QUEUE_ID   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ptr_wr_en,
    input  logic [ADDR_W-1:0] ptr_wr_data,
    input  logic              en_strobe,
    input  logic [PRI_W-1:0]  en_qsel,
    input  logic              consume,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [ADDR_W-1:0] rd_rsp_data,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              end_of_list,
    output logic              walker_busy,
    output logic              misalign_flag
);
    import rxw_pkg::*;

    localparam logic [PRI_W-1:0] QMASK = PRI_W'(1) << QUEUE_ID;

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] ptr;
        logic              mis;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic              strobe_hit;
    logic              fetch_start;
    logic              rsp_take;
    logic [ADDR_W-1:0] align_in;
    logic [ADDR_W-1:0] align_out;
    logic              align_bad;

    assign strobe_hit = en_strobe && (|(en_qsel & QMASK));

    // During a fetch, software writes are ignored, so one aligner serves both paths.
    assign align_in = (r_q.st == WS_FETCH) ? rd_rsp_data : ptr_wr_data;

    rxw_align #(
        .ADDR_W    (ADDR_W),
        .ALIGN_BITS(ALIGN_BITS)
    ) u_align (
        .raw_addr      (align_in),
        .aligned_addr  (align_out),
        .was_misaligned(align_bad)
    );

    rxw_fetch_port u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .start       (fetch_start),
        .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid),
        .rd_req_valid(rd_req_valid),
        .rsp_take    (rsp_take)
    );

    always_comb begin
        r_d         = r_q;
        fetch_start = 1'b0;
        unique case (r_q.st)
            WS_IDLE: begin
                if (ptr_wr_en) begin
                    r_d.ptr = align_out;
                    r_d.mis = r_q.mis | align_bad;
                end
                if (strobe_hit) begin
                    r_d.st = WS_ACTIVE;
                end
            end
            WS_ACTIVE: begin
                if (consume) begin
                    r_d.st      = WS_FETCH;
                    fetch_start = 1'b1;
                end
            end
            WS_FETCH: begin
                if (rsp_take) begin
                    if (align_out == '0) begin
                        r_d.st = WS_PARKED;
                    end else begin
                        r_d.st  = WS_ACTIVE;
                        r_d.ptr = align_out;
                    end
                end
            end
            WS_PARKED: begin
                if (strobe_hit) begin
                    r_d.st      = WS_FETCH;
                    fetch_start = 1'b1;
                end
            end
            default: r_d.st = WS_IDLE;
        endcase
        if (soft_rst) begin
            r_d         = '{st: WS_IDLE, ptr: '0, mis: 1'b0};
            fetch_start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: WS_IDLE, ptr: '0, mis: 1'b0};
        else        r_q <= r_d;
    end

    assign cur_ptr       = r_q.ptr;
    assign rd_req_addr   = r_q.ptr;
    assign end_of_list   = (r_q.st == WS_PARKED);
    assign walker_busy   = (r_q.st != WS_IDLE);
    assign misalign_flag = r_q.mis;
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 3,
    parameter int PRI_W      = 4,
    parameter int QUEUE_ID   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              ptr_wr_en,
    input logic              en_strobe,
    input logic [PRI_W-1:0]  en_qsel,
    input logic              consume,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              rd_rsp_valid,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic              end_of_list,
    input logic              walker_busy,
    input logic              misalign_flag
);
    localparam logic [PRI_W-1:0] CMASK = PRI_W'(1) << QUEUE_ID;
    logic hit;
    assign hit = en_strobe && (|(en_qsel & CMASK));

    // R1
    soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cur_ptr == '0) && !walker_busy && !misalign_flag && !rd_req_valid);

    // R2
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walker_busy && ptr_wr_en && !rd_rsp_valid && !soft_rst) |=> $stable(cur_ptr));

    // R3
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ptr[ALIGN_BITS-1:0] == '0);

    // R3
    misalign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign_flag && !soft_rst) |=> misalign_flag);

    // R5
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready && !soft_rst) |=> rd_req_valid && $stable(rd_req_addr));

    // R7
    parked_is_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_list |-> walker_busy);

    // R8
    park_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_list && !hit && !soft_rst) |=> end_of_list && $stable(cur_ptr));

    // R9
    idle_consume_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!walker_busy && consume && !soft_rst) |=> !rd_req_valid);
endmodule

bind rx_desc_walker rxw_checker #(
    .ADDR_W    (ADDR_W),
    .ALIGN_BITS(ALIGN_BITS),
    .PRI_W     (PRI_W),
    .QUEUE_ID  (QUEUE_ID)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .ptr_wr_en    (ptr_wr_en),
    .en_strobe    (en_strobe),
    .en_qsel      (en_qsel),
    .consume      (consume),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .cur_ptr      (cur_ptr),
    .end_of_list  (end_of_list),
    .walker_busy  (walker_busy),
    .misalign_flag(misalign_flag)
);

// File: tb/rx_desc_walker_test.sv
module rx_desc_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        ptr_wr_en = 1'b0;
    logic [31:0] ptr_wr_data = '0;
    logic        en_strobe = 1'b0;
    logic [3:0]  en_qsel = '0;
    logic        consume = 1'b0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [31:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic [31:0] cur_ptr;
    logic        end_of_list;
    logic        walker_busy;
    logic        misalign_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_desc_walker uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
        .en_strobe(en_strobe), .en_qsel(en_qsel), .consume(consume),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .cur_ptr(cur_ptr),
        .end_of_list(end_of_list), .walker_busy(walker_busy),
        .misalign_flag(misalign_flag)
    );

    // {op (1 = strobe, 0 = consume), link word, expected pointer, expected end_of_list}
    localparam int NVEC = 6;
    localparam logic [65:0] VEC [NVEC] = '{
        {1'b0, 32'h0000_0200, 32'h0000_0200, 1'b0},
        {1'b0, 32'h0000_03F8, 32'h0000_03F8, 1'b0},
        {1'b0, 32'h0000_0000, 32'h0000_03F8, 1'b1},
        {1'b1, 32'h0000_0000, 32'h0000_03F8, 1'b1},
        {1'b1, 32'h0000_040C, 32'h0000_0408, 1'b0},
        {1'b0, 32'h0000_1000, 32'h0000_1000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pulse consume (op=0) or a strobe with the given select for one cycle; ends one negedge later.
    task automatic kick(input bit op, input logic [3:0] sel);
        @(negedge clk);
        if (op) begin en_strobe = 1'b1; en_qsel = sel; end
        else consume = 1'b1;
        @(negedge clk);
        consume = 1'b0; en_strobe = 1'b0; en_qsel = '0;
    endtask

    task automatic wr(input logic [31:0] val);
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_data = val;
        @(negedge clk);
        ptr_wr_en = 1'b0;
    endtask

    // Called at the negedge where the request should be visible.
    task automatic serve(input logic [31:0] link, input logic [31:0] exp_addr, input string tag);
        chk({tag, " R5 request valid"}, 32'(rd_req_valid), 32'd1);
        chk({tag, " R5 request address"}, rd_req_addr, exp_addr);
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b1; rd_rsp_data = link;
        @(negedge clk);
        rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        // R1: hard reset state
        chk("R1 ptr after reset", cur_ptr, 32'h0);
        chk("R1 eol after reset", 32'(end_of_list), 32'd0);
        chk("R1 busy after reset", 32'(walker_busy), 32'd0);
        chk("R1 flag after reset", 32'(misalign_flag), 32'd0);
        chk("R1 req after reset", 32'(rd_req_valid), 32'd0);
        rst_n = 1'b1;

        // R9: consume while idle
        kick(1'b0, 4'h0);
        chk("R9 idle consume no request", 32'(rd_req_valid), 32'd0);
        chk("R9 idle consume stays idle", 32'(walker_busy), 32'd0);

        // R4: strobe without this queue's bit
        kick(1'b1, 4'b0111);
        chk("R4 wrong queue bit no start", 32'(walker_busy), 32'd0);

        // R3: misaligned load while idle (also R2 idle write accepted)
        wr(32'h0000_0105);
        chk("R3 aligned load", cur_ptr, 32'h0000_0100);
        chk("R3 misalign flag set", 32'(misalign_flag), 32'd1);

        // R4: start
        kick(1'b1, 4'b1000);
        chk("R4 start busy", 32'(walker_busy), 32'd1);
        chk("R4 start not parked", 32'(end_of_list), 32'd0);

        // R2: write while busy ignored
        wr(32'h0000_ABC0);
        chk("R2 busy write ignored", cur_ptr, 32'h0000_0100);

        // R8: strobe while waiting for consume has no effect
        kick(1'b1, 4'b1000);
        chk("R8 strobe while active no request", 32'(rd_req_valid), 32'd0);

        // Vector walk: R6 / R7 / R8
        prev = 32'h0000_0100;
        for (int i = 0; i < NVEC; i++) begin
            kick(VEC[i][65], 4'b1000);
            serve(VEC[i][64:33], prev, "R6/R7/R8 vector");
            chk("R6/R7 vector pointer", cur_ptr, VEC[i][32:1]);
            chk("R7/R8 vector end_of_list", 32'(end_of_list), 32'(VEC[i][0]));
            prev = VEC[i][32:1];
        end

        // R5: request held until ready
        kick(1'b0, 4'h0);
        repeat (3) @(negedge clk);
        chk("R5 request held without ready", 32'(rd_req_valid), 32'd1);
        chk("R5 pointer unchanged while pending", cur_ptr, 32'h0000_1000);
        serve(32'h0, 32'h0000_1000, "R5 held");
        chk("R7 parked after null link", 32'(end_of_list), 32'd1);
        chk("R7 parked pointer", cur_ptr, 32'h0000_1000);

        // R9: consume while parked
        kick(1'b0, 4'h0);
        chk("R9 parked consume no request", 32'(rd_req_valid), 32'd0);
        chk("R9 still parked", 32'(end_of_list), 32'd1);

        // R3: flag sticky
        chk("R3 flag sticky", 32'(misalign_flag), 32'd1);

        // R1: soft reset
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R1 soft reset ptr", cur_ptr, 32'h0);
        chk("R1 soft reset busy", 32'(walker_busy), 32'd0);
        chk("R1 soft reset eol", 32'(end_of_list), 32'd0);
        chk("R1 soft reset flag", 32'(misalign_flag), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule